// File: doc/BRIEF.md
# Dual Selectable Prescaler Clock Enables

This block gives a serial unit two independent operation-clock enables. Both come from one shared free-running prescaler that runs in the peripheral clock domain. A 16-bit configuration register holds one 4-bit selector per output. A selector value picks either a power-of-two division of the peripheral clock or an external timer tick. Each output is a clock-enable qualifier: it is high for exactly one cycle of the peripheral clock per selected period. No clock is generated or switched.

The unit-enable input powers the prescaler. While it is low, the prescaler is held at zero and both enables stay low. Configuration writes are accepted only once the unit has been enabled for a settling interval, and only while the stop-status input reports that every serial channel is idle. A write that breaks either rule is dropped and raises a sticky error flag. The same flag reports prohibited selector values and nonzero reserved bits. The parameter `UNIT_SEL` decides which of the two tick inputs the block uses: 0 picks tick A and 1 picks tick B.

Top module: `ckdiv_pair`

## Requirements
- R1: After synchronous reset the register reads 0000h, the error flag is low, and both enables are low while unit_en is low.
- R2: Register bits 3:0 select the source of cke0, and bits 7:4 select the source of cke1.
- R3: A selector value k from 1 to 11 makes the enable high only in cycles where the prescaler count, taken modulo 2^k, equals 2^k-1. That is one single-cycle pulse every 2^k cycles. The count is 0 in the first cycle with unit_en high and rises by one each cycle.
- R4: Selector value 0 holds the enable high on every cycle while unit_en is high.
- R5: Selector value 15 makes the enable follow tick_a in the same cycle, with unit_en high and UNIT_SEL=0. Under that setting tick_b has no effect.
- R6: Selector values 12, 13 and 14 hold that enable low, and accepting such a value sets the error flag.
- R7: An accepted write with both fields in 0 to 11 or 15 and bits 15:8 zero clears the error flag.
- R8: A write is accepted only if unit_en has been high for at least 4 preceding clock edges. An earlier write leaves the register unchanged and sets the error flag.
- R9: A write while chan_idle is low leaves the register unchanged and sets the error flag.
- R10: While unit_en is low both enables are low, and the prescaler count restarts from 0 when unit_en goes high again.
- R11: Bits 15:8 always read as zero. An accepted write with any of them set still loads bits 7:0 but sets the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_en | input | 1 | Unit enable; low holds prescaler at zero |
| chan_idle | input | 1 | High when all serial channels are stopped |
| tick_a | input | 1 | External timer tick A |
| tick_b | input | 1 | External timer tick B |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data |
| cke0 | output | 1 | Operation-clock enable 0 |
| cke1 | output | 1 | Operation-clock enable 1 |
| cfg_err | output | 1 | Sticky configuration error flag |

## Verification
The bench uses every division in the range, including the 2048 division, whose first pulse lands on the 2048th enabled cycle; an off-by-one in the mask or the count would move every pulse by a cycle. It places a write one edge inside the settling window and another while a channel is running; a design that accepts either one changes the readback and leaves the error flag low. It feeds tick A and tick B in opposite patterns, so a design that routes the wrong tick mismatches on every cycle. It also loads the prohibited values and reserved bits, then drops unit_en in the middle of a period; a design that keeps its count across the drop would send the first pulse after re-enable early.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;

    localparam int SEL_W     = 4;
    localparam int REG_W     = 16;
    localparam int FIELD_CNT = 2;
    localparam logic [SEL_W-1:0] TICK_CODE = 4'hF;

    typedef enum logic [1:0] {
        SRC_DIV,
        SRC_TICK,
        SRC_BAD
    } src_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel1;
        logic [SEL_W-1:0] sel0;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    function automatic src_e classify(input logic [SEL_W-1:0] code, input int stages);
        if (int'(code) < stages)
            return SRC_DIV;
        else if (code == TICK_CODE)
            return SRC_TICK;
        else
            return SRC_BAD;
    endfunction

    function automatic logic cfg_clean(input cfg_t c, input int stages);
        return (classify(c.sel0, stages) != SRC_BAD) && (classify(c.sel1, stages) != SRC_BAD);
    endfunction

endpackage

// File: rtl/ckdiv_prescaler.sv
module ckdiv_prescaler #(
    parameter int STAGES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic [STAGES-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0)) else $error("prescaler not cleared"); // R10

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        run |=> (cnt == STAGES'($past(cnt) + 1'b1))) else $error("prescaler step"); // R3

endmodule

// File: rtl/ckdiv_cfg.sv
module ckdiv_cfg
    import ckdiv_pkg::*;
#(
    parameter int STAGES = 12,
    parameter int SETTLE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             chan_idle,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output cfg_t             cfg,
    output logic             err
);

    localparam int SW = $clog2(SETTLE + 1);
    localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE);

    logic [SW-1:0] settle;
    logic          settled;
    logic          accept;
    cfg_t          wr_cfg;
    logic          rsvd_set;

    assign settled  = (settle == SETTLE_V);
    assign accept   = wr_en && run && chan_idle && settled;
    assign wr_cfg   = cfg_t'(wr_data[CFG_W-1:0]);
    assign rsvd_set = |wr_data[REG_W-1:CFG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            settle <= '0;
            cfg    <= '0;
            err    <= 1'b0;
        end else begin
            if (!run)
                settle <= '0;
            else if (!settled)
                settle <= settle + 1'b1;

            if (accept) begin
                cfg <= wr_cfg;
                err <= rsvd_set || !cfg_clean(wr_cfg, STAGES);
            end else if (wr_en) begin
                err <= 1'b1;
            end
        end
    end

    AST_EARLY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !settled) |=> ($stable(cfg) && err)) else $error("early write taken"); // R8

    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !chan_idle) |=> ($stable(cfg) && err)) else $error("busy write taken"); // R9

    AST_LEGAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && run && chan_idle && settled && !rsvd_set && cfg_clean(wr_cfg, STAGES))
        |=> !err) else $error("legal write kept error"); // R7

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(cfg) && (err || !$past(err)))) else $error("config drift"); // R2

endmodule

// File: rtl/ckdiv_select.sv
module ckdiv_select
    import ckdiv_pkg::*;
#(
    parameter int STAGES = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [SEL_W-1:0]  code,
    input  logic [STAGES-1:0] cnt,
    input  logic              tick,
    output logic              cke
);

    src_e              src;
    logic [STAGES-1:0] mask;
    logic              hit;

    assign src  = classify(code, STAGES);
    assign mask = (src == SRC_DIV) ? ((STAGES'(1) << code) - STAGES'(1)) : '0;
    assign hit  = ((cnt & mask) == mask);

    always_comb begin
        unique case (src)
            SRC_DIV:  cke = run && hit;
            SRC_TICK: cke = run && tick;
            default:  cke = 1'b0;
        endcase
    end

    AST_BAD_SILENT: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_BAD) |-> !cke) else $error("prohibited code active"); // R6

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !run |-> !cke) else $error("enable while unit off"); // R10

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cke && src == SRC_DIV && code != '0) |=> (!cke || code != $past(code)))
        else $error("pulse wider than one cycle"); // R3

endmodule

// File: rtl/ckdiv_pair.sv
module ckdiv_pair
    import ckdiv_pkg::*;
#(
    parameter int STAGES   = 12,
    parameter int SETTLE   = 4,
    parameter int UNIT_SEL = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        unit_en,
    input  logic        chan_idle,
    input  logic        tick_a,
    input  logic        tick_b,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        cke0,
    output logic        cke1,
    output logic        cfg_err
);

    logic [STAGES-1:0]          cnt;
    cfg_t                       cfg;
    logic                       tick;
    logic [FIELD_CNT-1:0][SEL_W-1:0] codes;
    logic [FIELD_CNT-1:0]       cke;

    generate
        if (UNIT_SEL == 0) begin : g_tick_a
            assign tick = tick_a;
        end else begin : g_tick_b
            assign tick = tick_b;
        end
    endgenerate

    ckdiv_prescaler #(.STAGES(STAGES)) u_pre (
        .clk (clk),
        .rst (rst),
        .run (unit_en),
        .cnt (cnt)
    );

    ckdiv_cfg #(.STAGES(STAGES), .SETTLE(SETTLE)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .run       (unit_en),
        .chan_idle (chan_idle),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cfg       (cfg),
        .err       (cfg_err)
    );

    assign codes[0] = cfg.sel0;
    assign codes[1] = cfg.sel1;

    generate
        for (genvar i = 0; i < FIELD_CNT; i++) begin : g_sel
            ckdiv_select #(.STAGES(STAGES)) u_sel (
                .clk  (clk),
                .rst  (rst),
                .run  (unit_en),
                .code (codes[i]),
                .cnt  (cnt),
                .tick (tick),
                .cke  (cke[i])
            );
        end
    endgenerate

    assign cke0    = cke[0];
    assign cke1    = cke[1];
    assign rd_data = {{(REG_W-CFG_W){1'b0}}, cfg};

endmodule

// File: tb/ckdiv_pair_test.sv
module ckdiv_pair_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        unit_en = 1'b0;
    logic        chan_idle = 1'b1;
    logic        tick_a = 1'b0;
    logic        tick_b = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        cke0, cke1, cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    string phase = "R1";

    int m_cnt = 0;
    int m_settle = 0;
    int m_sel0 = 0;
    int m_sel1 = 0;
    bit m_err = 0;

    always #4 clk = ~clk;

    ckdiv_pair uut (
        .clk(clk), .rst(rst), .unit_en(unit_en), .chan_idle(chan_idle),
        .tick_a(tick_a), .tick_b(tick_b), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cke0(cke0), .cke1(cke1), .cfg_err(cfg_err)
    );

    function automatic bit bad_code(int c);
        return (c >= 12 && c <= 14);
    endfunction

    function automatic bit exp_cke(int c);
        if (!unit_en) return 0;
        if (c <= 11) return (m_cnt % (1 << c)) == ((1 << c) - 1);
        if (c == 15) return tick_a;
        return 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_cnt = 0; m_settle = 0; m_sel0 = 0; m_sel1 = 0; m_err = 0;
        end else begin
            if (wr_en) begin
                if (unit_en && chan_idle && m_settle >= 4) begin
                    m_sel0 = wr_data[3:0];
                    m_sel1 = wr_data[7:4];
                    m_err  = bad_code(m_sel0) || bad_code(m_sel1) || (wr_data[15:8] != 0);
                end else begin
                    m_err = 1;
                end
            end
            if (!unit_en) begin
                m_cnt = 0; m_settle = 0;
            end else begin
                m_cnt = (m_cnt + 1) % 4096;
                if (m_settle < 4) m_settle++;
            end
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({phase, " cke0"}, int'(cke0), int'(exp_cke(m_sel0)));
        chk({phase, " cke1"}, int'(cke1), int'(exp_cke(m_sel1)));
        chk({phase, " rd_data"}, int'(rd_data), (m_sel1 << 4) | m_sel0);
        chk({phase, " cfg_err"}, int'(cfg_err), int'(m_err));
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        cyc();
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        phase = "R1";
        run(3);
        rst = 1'b0;
        run(2);
        chk("R1 reset readback", int'(rd_data), 0);

        // R4: code 0 on both outputs
        phase = "R4";
        unit_en = 1'b1;
        run(6);
        chk("R4 cke0 held high", int'(cke0), 1);

        // R10 then R8: drop enable, write inside settling window
        phase = "R10";
        unit_en = 1'b0;
        run(2);
        chk("R10 cke1 low while off", int'(cke1), 0);
        unit_en = 1'b1;
        phase = "R8";
        run(3);
        wr(16'h0031);
        chk("R8 early write dropped", int'(rd_data), 0);
        chk("R8 early write flags", int'(cfg_err), 1);

        // R7 / R2 / R3: legal write, sel0=1, sel1=3
        phase = "R7";
        wr(16'h0031);
        chk("R7 legal write clears", int'(cfg_err), 0);
        phase = "R3";
        run(40);

        // R11: reserved bits, sel1=2, sel0=11 (divide by 2048)
        phase = "R11";
        wr(16'hFF2B);
        chk("R11 upper reads zero", int'(rd_data), 16'h002B);
        chk("R11 reserved bits flag", int'(cfg_err), 1);
        phase = "R3";
        run(4200);

        // R9: write while channels running
        phase = "R9";
        chan_idle = 1'b0;
        wr(16'h0000);
        chk("R9 busy write dropped", int'(rd_data), 16'h002B);
        chan_idle = 1'b1;
        run(2);

        // R6 / R5: sel1=12 prohibited, sel0=15 tick
        phase = "R6";
        wr(16'h00CF);
        chk("R6 prohibited flags", int'(cfg_err), 1);
        phase = "R5";
        for (int i = 0; i < 30; i++) begin
            tick_a = (i % 3 == 0);
            tick_b = !tick_a;
            cyc();
        end
        tick_a = 1'b0; tick_b = 1'b0;

        // R6 more prohibited values, then R7 recovery with sel0=0, sel1=7
        phase = "R6";
        wr(16'h00E5);
        run(3);
        wr(16'h000D);
        run(3);
        phase = "R7";
        wr(16'h0070);
        chk("R7 error cleared", int'(cfg_err), 0);
        phase = "R2";
        run(300);

        // R10: drop enable mid-period, restart from zero
        phase = "R10";
        unit_en = 1'b0;
        run(5);
        unit_en = 1'b1;
        run(260);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule